// File: doc/BRIEF.md
# Data Space Internal/External Router

This block sits between a processor's load/store path and its data space of 2^ADDR_W bytes. Each access carries one address, and the address alone picks the target. Addresses below a fixed boundary go to the on-chip resources: working registers, I/O, extended I/O and internal SRAM. Those accesses finish in the cycle they are issued. Addresses at or above the boundary go to an external SRAM port, which has active-low read and write strobes. That port is stretched by a stall that the core must honour.

The boundary depends on the memory map that is built. A map selector puts it at byte 4608 or at byte 8704. The external port works only while a configuration enable is set. With the enable clear, an access above the boundary returns zero at once, and the bus stays quiet. With the enable set, every external byte access costs one extra cycle plus the programmed wait states, which range from 0 to 3. The wait-state field is captured when the access starts.

The internal arrays are not part of the block. The router hands them a select and a write enable, and it takes their read data back through a mux.

Top module: `dspace_router`

## Requirements
- R1: An access whose address is below the boundary is internal: `int_sel` is 1 and no stall is raised. An address at or above the boundary is external. The boundary is 4608 when MAP_SEL=0 and 8704 when MAP_SEL=1.
- R2: During an internal access, `ext_rd_n` and `ext_wr_n` stay 1 and `core_stall` stays 0. `core_rdata` equals `int_rdata` in the same cycle, and `int_we` follows `core_we`.
- R3: While `cfg_ext_en` is 0, an access above the boundary completes in one cycle with no stall. It returns `core_rdata`=0, leaves both strobes at 1 and keeps `int_sel` at 0.
- R4: With `cfg_ext_en`=1 and `cfg_wait`=0, an external access raises `core_stall` for exactly one cycle, so it takes two cycles in total. Its strobe is low (active) only in the second cycle.
- R5: With `cfg_wait`=W (a 2-bit code, 1 to 3), an external access raises `core_stall` for W+1 cycles. Its strobe is low for W+1 cycles, from the second cycle through the last cycle.
- R6: `cfg_wait` is sampled in the first cycle of an external access. Changing it later in that access does not change the length of the access.
- R7: During an external write, `ext_oe`=1 and `ext_dout`=`core_wdata` from the first cycle onward. `ext_wr_n` (0 = active) goes low no earlier than the second cycle, and `ext_rd_n` stays 1.
- R8: During an external read, `ext_oe` is 0 and `ext_wr_n` stays 1. `core_rdata` equals `ext_din` in the final, unstalled cycle.
- R9: `ext_addr` equals `core_addr` in every cycle of an external access.
- R10: After reset, with no request pending, both strobes are 1, `core_stall` is 0 and `ext_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ext_en | input | 1 | Enables the external SRAM port |
| cfg_wait | input | WS_W | Wait-state count for external accesses |
| core_req | input | 1 | Core access request, held while stalled |
| core_we | input | 1 | 1 = write, 0 = read |
| core_addr | input | ADDR_W | Data-space byte address |
| core_wdata | input | DATA_W | Write data from the core |
| core_rdata | output | DATA_W | Read data returned to the core |
| core_stall | output | 1 | Stretches the current access |
| int_sel | output | 1 | Selects the internal memories |
| int_we | output | 1 | Write enable for the internal memories |
| int_rdata | input | DATA_W | Read data from the internal memories |
| ext_addr | output | ADDR_W | External SRAM address |
| ext_dout | output | DATA_W | External write data |
| ext_oe | output | 1 | Drive enable for the external data bus |
| ext_din | input | DATA_W | External read data |
| ext_rd_n | output | 1 | External read strobe, active low |
| ext_wr_n | output | 1 | External write strobe, active low |

## Verification
The bench sweeps addresses on both sides of each boundary, both directions, both enable states and every wait code, and counts each cycle of every access. Each sweep targets a specific fault:
- An off-by-one boundary would send byte 4607 or 4608 to the wrong side.
- A miscounted wait stretch would report a length other than W+2.
- A wait field read live instead of latched would track the perturbed value the bench writes mid-access.
- A strobe asserted in the address-setup cycle would show a low strobe in cycle 0.

Accesses above the boundary with the port disabled must show no strobe and return zero. Reads must deliver the external bus value exactly on the unstalled cycle. A second instance with the large map confirms that the boundary moves with the map selector.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

   typedef enum logic [1:0] {
      RG_INT = 2'd0,
      RG_EXT = 2'd1,
      RG_OFF = 2'd2
   } region_t;

   localparam int unsigned MAP_SMALL_BYTES = 4608;
   localparam int unsigned MAP_LARGE_BYTES = 8704;

   function automatic int unsigned map_bound(input int sel);
      return (sel == 0) ? MAP_SMALL_BYTES : MAP_LARGE_BYTES;
   endfunction

endpackage

// File: rtl/dsr_decode.sv
module dsr_decode
   import dsr_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int MAP_SEL = 0
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              ext_en,
   output region_t           region
);
   localparam int unsigned BOUND_I = map_bound(MAP_SEL);
   localparam logic [ADDR_W-1:0] BOUND = ADDR_W'(BOUND_I);

   logic below;

   generate
      if (ADDR_W < 14 || ADDR_W > 24) begin : g_bad_width
         $error("dsr_decode: ADDR_W out of range");
      end
      if (MAP_SEL != 0 && MAP_SEL != 1) begin : g_bad_map
         $error("dsr_decode: MAP_SEL must be 0 or 1");
      end
      if (MAP_SEL == 0) begin : g_small
         assign below = (addr < BOUND);
      end else begin : g_large
         assign below = (addr < BOUND);
      end
   endgenerate

   always_comb begin
      if (below)       region = RG_INT;
      else if (ext_en) region = RG_EXT;
      else             region = RG_OFF;
   end
endmodule

// File: rtl/dsr_ext_seq.sv
module dsr_ext_seq #(
   parameter int WS_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            we,
   input  logic [WS_W-1:0] ws,
   output logic            active,
   output logic            busy,
   output logic            last,
   output logic            stall,
   output logic            rd_n,
   output logic            wr_n
);
   localparam int REM_W = WS_W + 1;

   logic             busy_q;
   logic [REM_W-1:0] rem_q;
   logic [WS_W-1:0]  ws_q;
   logic             rd_n_q, wr_n_q;
   logic             go;

   generate
      if (WS_W < 1 || WS_W > 4) begin : g_bad_ws
         $error("dsr_ext_seq: WS_W out of range");
      end
   endgenerate

   assign go     = start & ~busy_q;
   assign busy   = busy_q;
   assign active = go | busy_q;
   assign last   = busy_q & (rem_q == REM_W'(1));
   assign stall  = go | (busy_q & ~last);
   assign rd_n   = rd_n_q;
   assign wr_n   = wr_n_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         rem_q  <= '0;
         ws_q   <= '0;
         rd_n_q <= 1'b1;
         wr_n_q <= 1'b1;
      end else if (go) begin
         busy_q <= 1'b1;
         rem_q  <= REM_W'(ws) + REM_W'(1);
         ws_q   <= ws;
         rd_n_q <= we;
         wr_n_q <= ~we;
      end else if (last) begin
         busy_q <= 1'b0;
         rem_q  <= '0;
         rd_n_q <= 1'b1;
         wr_n_q <= 1'b1;
      end else if (busy_q) begin
         rem_q  <= rem_q - REM_W'(1);
      end
   end

   // stall-run counter for checking
   logic [REM_W:0] run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     run_q <= '0;
      else if (stall) run_q <= run_q + 1'b1;
      else            run_q <= '0;
   end

   AST_STALL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      last |-> (run_q == (REM_W+1)'(ws_q) + (REM_W+1)'(1))); // R5
   AST_SETUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> (rd_n_q && wr_n_q)); // R7
   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n_q && !wr_n_q)); // R8
   AST_LAST_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      last |-> (!rd_n_q || !wr_n_q)); // R4
endmodule

// File: rtl/dsr_rdmux.sv
module dsr_rdmux #(
   parameter int DATA_W = 8
) (
   input  logic              sel_int,
   input  logic              ext_take,
   input  logic [DATA_W-1:0] int_rdata,
   input  logic [DATA_W-1:0] ext_din,
   output logic [DATA_W-1:0] rdata
);
   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("dsr_rdmux: DATA_W must be positive");
      end
   endgenerate

   always_comb begin
      if (sel_int)       rdata = int_rdata;
      else if (ext_take) rdata = ext_din;
      else               rdata = '0;
   end
endmodule

// File: rtl/dspace_router.sv
module dspace_router
   import dsr_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 8,
   parameter int WS_W    = 2,
   parameter int MAP_SEL = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_ext_en,
   input  logic [WS_W-1:0]   cfg_wait,
   input  logic              core_req,
   input  logic              core_we,
   input  logic [ADDR_W-1:0] core_addr,
   input  logic [DATA_W-1:0] core_wdata,
   output logic [DATA_W-1:0] core_rdata,
   output logic              core_stall,
   output logic              int_sel,
   output logic              int_we,
   input  logic [DATA_W-1:0] int_rdata,
   output logic [ADDR_W-1:0] ext_addr,
   output logic [DATA_W-1:0] ext_dout,
   output logic              ext_oe,
   input  logic [DATA_W-1:0] ext_din,
   output logic              ext_rd_n,
   output logic              ext_wr_n
);
   region_t region;
   logic    seq_active, seq_busy, seq_last, seq_start;

   dsr_decode #(.ADDR_W(ADDR_W), .MAP_SEL(MAP_SEL)) u_dec (
      .addr   (core_addr),
      .ext_en (cfg_ext_en),
      .region (region)
   );

   assign seq_start = core_req & (region == RG_EXT);

   dsr_ext_seq #(.WS_W(WS_W)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (seq_start),
      .we     (core_we),
      .ws     (cfg_wait),
      .active (seq_active),
      .busy   (seq_busy),
      .last   (seq_last),
      .stall  (core_stall),
      .rd_n   (ext_rd_n),
      .wr_n   (ext_wr_n)
   );

   assign int_sel  = core_req & (region == RG_INT);
   assign int_we   = int_sel & core_we;
   assign ext_addr = seq_active ? core_addr : '0;
   assign ext_oe   = seq_active & core_we;
   assign ext_dout = (seq_active & core_we) ? core_wdata : '0;

   dsr_rdmux #(.DATA_W(DATA_W)) u_mux (
      .sel_int   (int_sel),
      .ext_take  (seq_last & ~core_we),
      .int_rdata (int_rdata),
      .ext_din   (ext_din),
      .rdata     (core_rdata)
   );

   AST_INT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      int_sel |-> (ext_rd_n && ext_wr_n && !core_stall)); // R2
   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_ext_en && !seq_busy) |-> (ext_rd_n && ext_wr_n)); // R3
   AST_WR_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_wr_n |-> (ext_oe && ext_dout == core_wdata)); // R7
   AST_RD_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_rd_n |-> !ext_oe); // R8
   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      core_stall |=> (ext_addr == $past(core_addr))); // R9
endmodule

// File: tb/sim_dspace_router.sv
module sim_dspace_router;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_ext_en = 1'b0;
   logic [1:0]  cfg_wait = 2'd0;
   logic        core_req = 1'b0;
   logic        core_we = 1'b0;
   logic [15:0] core_addr = '0;
   logic [7:0]  core_wdata = '0;
   logic [7:0]  core_rdata, int_rdata, ext_din, ext_dout;
   logic        core_stall, int_sel, int_we, ext_oe, ext_rd_n, ext_wr_n;
   logic [15:0] ext_addr;

   logic [7:0]  u1_rdata, u1_dout;
   logic        u1_stall, u1_int_sel, u1_int_we, u1_oe, u1_rd_n, u1_wr_n;
   logic [15:0] u1_addr;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   assign int_rdata = core_addr[7:0] ^ 8'h5A;
   assign ext_din   = core_addr[15:8] ^ core_addr[7:0] ^ 8'hC3;

   dspace_router u0 (
      .clk(clk), .rst_n(rst_n), .cfg_ext_en(cfg_ext_en), .cfg_wait(cfg_wait),
      .core_req(core_req), .core_we(core_we), .core_addr(core_addr),
      .core_wdata(core_wdata), .core_rdata(core_rdata), .core_stall(core_stall),
      .int_sel(int_sel), .int_we(int_we), .int_rdata(int_rdata),
      .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_oe(ext_oe),
      .ext_din(ext_din), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n)
   );

   dspace_router #(.MAP_SEL(1)) u1 (
      .clk(clk), .rst_n(rst_n), .cfg_ext_en(cfg_ext_en), .cfg_wait(cfg_wait),
      .core_req(core_req), .core_we(core_we), .core_addr(core_addr),
      .core_wdata(core_wdata), .core_rdata(u1_rdata), .core_stall(u1_stall),
      .int_sel(u1_int_sel), .int_we(u1_int_we), .int_rdata(int_rdata),
      .ext_addr(u1_addr), .ext_dout(u1_dout), .ext_oe(u1_oe),
      .ext_din(ext_din), .ext_rd_n(u1_rd_n), .ext_wr_n(u1_wr_n)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic access(input logic [15:0] a, input bit we, input bit en, input logic [1:0] ws);
      bit          is_int;
      int          n_exp, c, strobes;
      logic [7:0]  wd;
      is_int = (a < 16'd4608);
      wd     = a[7:0] + 8'h11;
      @(negedge clk);
      core_req = 1'b1; core_we = we; core_addr = a; core_wdata = wd;
      cfg_ext_en = en; cfg_wait = ws;
      n_exp = (is_int || !en) ? 1 : ws + 2;
      c = 0; strobes = 0;
      forever begin
         #1;
         if (is_int) begin
            chk("R1 int_sel", int_sel, 1);
            chk("R2 strobes", {ext_rd_n, ext_wr_n}, 2'b11);
            chk("R2 int_we", int_we, we);
            if (!we) chk("R2 rdata", core_rdata, a[7:0] ^ 8'h5A);
         end else if (!en) begin
            chk("R3 int_sel", int_sel, 0);
            chk("R3 strobes", {ext_rd_n, ext_wr_n}, 2'b11);
            chk("R3 rdata", core_rdata, 0);
         end else begin
            chk("R1 int_sel", int_sel, 0);
            chk("R9 ext_addr", ext_addr, a);
            chk("R5 stall", core_stall, (c < n_exp - 1));
            if (we) begin
               chk("R7 oe", ext_oe, 1);
               chk("R7 dout", ext_dout, wd);
               chk("R7 rd_n", ext_rd_n, 1);
               chk("R7 wr_n", ext_wr_n, (c == 0));
               if (!ext_wr_n) strobes++;
            end else begin
               chk("R8 oe", ext_oe, 0);
               chk("R8 wr_n", ext_wr_n, 1);
               chk("R4 rd_n", ext_rd_n, (c == 0));
               if (!ext_rd_n) strobes++;
               if (!core_stall) chk("R8 rdata", core_rdata, a[15:8] ^ a[7:0] ^ 8'hC3);
            end
         end
         c++;
         if (!core_stall || c > 8) break;
         @(negedge clk);
         if (c == 1) cfg_wait = ~ws; // R6 perturb after start
      end
      chk((ws == 0) ? "R4 length" : "R5 length", c, n_exp);
      if (!is_int && en) begin
         chk("R6 length", c, ws + 2);
         chk("R5 strobe count", strobes, ws + 1);
      end
      @(negedge clk);
      core_req = 1'b0; cfg_wait = ws;
      #1;
      chk("R10 idle strobes", {ext_rd_n, ext_wr_n, core_stall}, 3'b110);
   endtask

   initial begin
      logic [15:0] addrs [10];
      addrs = '{16'h0000, 16'h0001, 16'd4607, 16'd4608, 16'd4609,
                16'd8703, 16'd8704, 16'h8000, 16'h1000, 16'hFFFF};
      #9 rst_n = 1'b1;
      @(negedge clk); #1;
      chk("R10 strobes", {ext_rd_n, ext_wr_n}, 2'b11);
      chk("R10 stall", core_stall, 0);
      chk("R10 oe", ext_oe, 0);
      // large-map boundary on u1
      @(negedge clk);
      core_req = 1'b1; cfg_ext_en = 1'b0; core_addr = 16'd8703; #1;
      chk("R1 large map below", u1_int_sel, 1);
      core_addr = 16'd8704; #1;
      chk("R1 large map at", u1_int_sel, 0);
      core_addr = 16'd4608; #1;
      chk("R1 large map mid", u1_int_sel, 1);
      @(negedge clk); core_req = 1'b0;
      for (int e = 0; e < 2; e++)
         for (int w = 0; w < 2; w++)
            for (int s = 0; s < 4; s++)
               for (int i = 0; i < 10; i++)
                  access(addrs[i], w[0], e[0], s[1:0]);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule